// File: doc/BRIEF.md
# SWD host transfer engine

This block is the host side of a two-wire serial debug link. It carries out one complete register access for each accepted request. A request is made of a 4-bit selector, 32 bits of write data and a one-cycle strobe. In the selector, bit 0 chooses the access port over the debug port, bit 1 marks a read, and bits 2 and 3 are the register address bits. The engine sends the packet header and releases the data line for the turnaround. It then samples the three acknowledge bits and either moves the data word with its parity bit or takes the recovery path that the acknowledge calls for. It ends with the configured number of idle clocks.

The serial clock and the data-line drive are generated from the system clock. A half-period setting, given in system clocks, sets the bit rate. Turnaround length, idle count and the dummy data-phase option are sampled when a request is accepted. At the end of each access the engine returns a 4-bit status and the read word, together with a one-cycle done pulse. It always leaves the serial clock high and the data line driven high between accesses.

Top module: `swd_xfer_engine`

## Requirements
- R1: The header is sent LSB-first on eight driven bit slots: 1, sel[0], sel[1], sel[2], sel[3], even parity of sel[3:0], 0, 1.
- R2: After the header, the data line is released (enable low) for T = cfg_turn+1 slots, and then three acknowledge bits are sampled LSB-first. OK is 3'b001, WAIT is 3'b010 and FAULT is 3'b100.
- R3: On OK with sel[1]=1, 32 data bits are sampled LSB-first, followed by a parity bit. The word appears on rdata, resp is 4'b0001, T released slots follow, and the line is then driven again.
- R4: On an OK read whose received parity is not the even parity of the word, resp is 4'b1000. rdata still carries the word received.
- R5: On OK with sel[1]=0, T released slots come first. Then the 32 write bits are driven LSB-first, followed by their even parity bit.
- R6: After any OK access, cfg_idle slots are driven low. After them the line is left driven high.
- R7: On WAIT or FAULT, resp is {1'b0, ack}. With cfg_dphase=1, a read clocks 33 released slots and then T released slots, and a write clocks T released slots and then 33 slots driven low. With cfg_dphase=0, only T released slots follow the acknowledge.
- R8: Any other acknowledge clocks T+33 released slots, and resp is {1'b0, ack}.
- R9: SWCLK is low for max(cfg_half,1) system clocks in each slot and high for the same time. SWDIO changes only on edges where SWCLK was high before the edge. SWCLK stays high whenever no access is running.
- R10: busy rises in the cycle after an accepted strobe. done is a one-cycle pulse, and busy is low in that cycle. Strobes seen while busy is high are ignored.
- R11: After reset, swclk=1, swdio_oe=1, swdio_o=1, busy=0 and done=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_sel | input | 4 | {A3, A2, read, access-port} |
| req_wdata | input | 32 | Write word |
| cfg_half | input | DIV_W | Half-period in system clocks (0 acts as 1) |
| cfg_turn | input | 2 | Turnaround length minus one |
| cfg_idle | input | IDLE_W | Idle slots after an OK access |
| cfg_dphase | input | 1 | Clock a dummy data phase on WAIT/FAULT |
| swclk | output | 1 | Serial clock |
| swdio_o | output | 1 | Data line drive value |
| swdio_oe | output | 1 | Data line drive enable |
| swdio_i | input | 1 | Data line sampled value |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| resp | output | 4 | Status code |
| rdata | output | 32 | Read word |

## Verification
The assertions take for granted that reset is applied before use. They also assume that a new strobe only needs to be honoured while busy is low, and that the configuration inputs matter only in the accept cycle. The bench holds every configuration input steady across each access. It raises strobes during busy only as probes that must be ignored. The target model changes swdio_i only at falling SWCLK edges, so the value is stable through the low half in which the engine samples it.

// File: rtl/swd_pkg.sv
package swd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_HDR, ST_TRNA, ST_ACK, ST_RDAT,
    ST_TRNB, ST_WDAT, ST_IDLC, ST_DUMR, ST_DUMW, ST_BOFF
  } seg_t;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;
  localparam logic [3:0] RESP_PERR = 4'b1000;
  localparam int         DATA_SLOTS = 33;
endpackage

// File: rtl/swd_clkgen.sv
module swd_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             halt,
  input  logic [DIV_W-1:0] half,
  output logic             swclk,
  output logic             smp,
  output logic             bnd
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             tick;

  assign lim  = (half == '0) ? '0 : half - 1'b1;
  assign tick = run && (cnt == lim);
  assign smp  = tick && !swclk;   // last cycle of the low half
  assign bnd  = tick && swclk;    // last cycle of the high half

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      swclk <= 1'b1;
    end else if (tick) begin
      cnt <= '0;
      if (!(swclk && halt)) swclk <= ~swclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/swd_seq.sv
module swd_seq
  import swd_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [3:0]        req_sel,
  input  logic [31:0]       req_wdata,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic [1:0]        cfg_turn,
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic              cfg_dphase,
  input  logic              smp,
  input  logic              bnd,
  input  logic              swdio_i,
  output logic              run,
  output logic              halt,
  output logic [DIV_W-1:0]  half_q,
  output logic              swdio_o,
  output logic              swdio_oe,
  output logic              busy,
  output logic              done,
  output logic [3:0]        resp,
  output logic [31:0]       rdata
);
  localparam int CW = (IDLE_W > 6) ? IDLE_W : 6;

  seg_t              st, nxt_st;
  logic [CW-1:0]     left, nxt_left;
  logic              fin;
  logic [7:0]        hsh;
  logic [32:0]       wsh, rsh;
  logic [2:0]        acks;
  logic              rnw, dph;
  logic [1:0]        turn;
  logic [IDLE_W-1:0] idle;
  logic              ack_ok, ack_wf;

  assign ack_ok = (acks == ACK_OK);
  assign ack_wf = (acks == ACK_WAIT) || (acks == ACK_FAULT);

  always_comb begin
    nxt_st   = st;
    nxt_left = left - 1'b1;
    fin      = 1'b0;
    if (left == '0) begin
      case (st)
        ST_PRE:  begin nxt_st = ST_HDR;  nxt_left = CW'(7); end
        ST_HDR:  begin nxt_st = ST_TRNA; nxt_left = CW'(turn); end
        ST_TRNA: begin nxt_st = ST_ACK;  nxt_left = CW'(2); end
        ST_ACK: begin
          if (ack_ok && rnw) begin
            nxt_st = ST_RDAT; nxt_left = CW'(DATA_SLOTS - 1);
          end else if (ack_wf && dph && rnw) begin
            nxt_st = ST_DUMR; nxt_left = CW'(DATA_SLOTS - 1);
          end else if (ack_ok || ack_wf) begin
            nxt_st = ST_TRNB; nxt_left = CW'(turn);
          end else begin
            nxt_st = ST_BOFF; nxt_left = CW'(turn) + CW'(DATA_SLOTS);
          end
        end
        ST_RDAT, ST_DUMR: begin nxt_st = ST_TRNB; nxt_left = CW'(turn); end
        ST_TRNB: begin
          if (ack_ok && !rnw) begin
            nxt_st = ST_WDAT; nxt_left = CW'(DATA_SLOTS - 1);
          end else if (ack_ok && idle != '0) begin
            nxt_st = ST_IDLC; nxt_left = CW'(idle) - 1'b1;
          end else if (!ack_ok && dph && !rnw) begin
            nxt_st = ST_DUMW; nxt_left = CW'(DATA_SLOTS - 1);
          end else begin
            fin = 1'b1;
          end
        end
        ST_WDAT: begin
          if (idle != '0) begin
            nxt_st = ST_IDLC; nxt_left = CW'(idle) - 1'b1;
          end else begin
            fin = 1'b1;
          end
        end
        default: fin = 1'b1;
      endcase
    end
  end

  assign halt = bnd && fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      left     <= '0;
      run      <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      swdio_o  <= 1'b1;
      swdio_oe <= 1'b1;
      resp     <= '0;
      rdata    <= '0;
      hsh      <= '0;
      wsh      <= '0;
      rsh      <= '0;
      acks     <= '0;
      rnw      <= 1'b0;
      dph      <= 1'b0;
      turn     <= '0;
      idle     <= '0;
      half_q   <= '0;
    end else begin
      done <= 1'b0;
      if (st == ST_IDLE) begin
        if (req_valid) begin
          st     <= ST_PRE;
          left   <= '0;
          run    <= 1'b1;
          busy   <= 1'b1;
          hsh    <= {2'b10, ^req_sel, req_sel, 1'b1};
          wsh    <= {^req_wdata, req_wdata};
          acks   <= '0;
          rnw    <= req_sel[1];
          dph    <= cfg_dphase;
          turn   <= cfg_turn;
          idle   <= cfg_idle;
          half_q <= cfg_half;
        end
      end else begin
        if (smp) begin
          if (st == ST_ACK)  acks <= {swdio_i, acks[2:1]};
          if (st == ST_RDAT) rsh  <= {swdio_i, rsh[32:1]};
        end
        if (bnd) begin
          if (fin) begin
            st       <= ST_IDLE;
            run      <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b1;
            swdio_o  <= 1'b1;
            swdio_oe <= 1'b1;
            resp     <= (ack_ok && rnw && (^rsh)) ? RESP_PERR : {1'b0, acks};
            if (ack_ok && rnw) rdata <= rsh[31:0];
          end else begin
            st   <= nxt_st;
            left <= nxt_left;
            case (nxt_st)
              ST_HDR: begin
                swdio_oe <= 1'b1; swdio_o <= hsh[0]; hsh <= {1'b0, hsh[7:1]};
              end
              ST_WDAT: begin
                swdio_oe <= 1'b1; swdio_o <= wsh[0]; wsh <= {1'b0, wsh[32:1]};
              end
              ST_IDLC, ST_DUMW: begin
                swdio_oe <= 1'b1; swdio_o <= 1'b0;
              end
              default: swdio_oe <= 1'b0;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/swd_xfer_engine.sv
module swd_xfer_engine #(
  parameter int DIV_W  = 8,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [3:0]        req_sel,
  input  logic [31:0]       req_wdata,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic [1:0]        cfg_turn,
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic              cfg_dphase,
  output logic              swclk,
  output logic              swdio_o,
  output logic              swdio_oe,
  input  logic              swdio_i,
  output logic              busy,
  output logic              done,
  output logic [3:0]        resp,
  output logic [31:0]       rdata
);
  logic             run, halt, smp, bnd;
  logic [DIV_W-1:0] half_q;

  swd_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(run), .halt(halt), .half(half_q),
    .swclk(swclk), .smp(smp), .bnd(bnd)
  );

  swd_seq #(.DIV_W(DIV_W), .IDLE_W(IDLE_W)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
    .req_wdata(req_wdata), .cfg_half(cfg_half), .cfg_turn(cfg_turn),
    .cfg_idle(cfg_idle), .cfg_dphase(cfg_dphase), .smp(smp), .bnd(bnd),
    .swdio_i(swdio_i), .run(run), .halt(halt), .half_q(half_q),
    .swdio_o(swdio_o), .swdio_oe(swdio_oe), .busy(busy), .done(done),
    .resp(resp), .rdata(rdata)
  );
endmodule

// File: rtl/swd_xfer_chk.sv
module swd_xfer_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic swclk,
  input logic swdio_o,
  input logic swdio_oe,
  input logic busy,
  input logic done
);
  AST_DIO_CHG_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!$stable(swdio_o) || !$stable(swdio_oe)) |-> $past(swclk)) else $error("dio change");  // R9
  AST_CLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> swclk) else $error("clk idle");  // R9
  AST_IDLE_DRIVEN_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (swdio_oe && swdio_o)) else $error("idle drive");  // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done width");  // R10
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))) else $error("done busy");  // R10
  AST_BUSY_FROM_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid)) else $error("busy start");  // R10
endmodule

bind swd_xfer_engine swd_xfer_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .swclk(swclk),
  .swdio_o(swdio_o), .swdio_oe(swdio_oe), .busy(busy), .done(done)
);

// File: tb/sim_swd_xfer_engine.sv
`timescale 1ns/1ps
module sim_swd_xfer_engine;
  typedef struct {
    logic [3:0]  resp;
    logic [31:0] rdata;
    bit          chk_rd;
    int          nslots;
    logic [7:0]  hdr;
    logic [31:0] wd;
    int          kind;   // 0 ok, 1 wait/fault, 2 protocol error
    bit          rnw, dph;
    int          t, idl, half;
  } exp_t;

  logic clk = 0, rst = 1;
  logic req_valid = 0;
  logic [3:0] req_sel = 0;
  logic [31:0] req_wdata = 0;
  logic [7:0] cfg_half = 1, cfg_idle = 0;
  logic [1:0] cfg_turn = 0;
  logic cfg_dphase = 0;
  logic swclk, swdio_o, swdio_oe, busy, done;
  logic swdio_i = 1;
  logic [3:0] resp;
  logic [31:0] rdata;

  int checks = 0, errors = 0, ndone = 0, ntx = 0;
  bit finished = 0;
  exp_t q[$];

  int slot = 0, tgt_t = 1, lowlen = 0;
  logic [2:0] tgt_ack = 3'b001;
  logic [31:0] tgt_rd = 0;
  bit tgt_bad = 0, tgt_rnw = 0;
  logic ro [0:511];
  logic roe [0:511];
  time tfall;

  always #4 clk = ~clk;

  swd_xfer_engine u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
    .req_wdata(req_wdata), .cfg_half(cfg_half), .cfg_turn(cfg_turn),
    .cfg_idle(cfg_idle), .cfg_dphase(cfg_dphase), .swclk(swclk),
    .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(swdio_i),
    .busy(busy), .done(done), .resp(resp), .rdata(rdata)
  );

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // target model: new bit on each falling SWCLK edge
  always @(negedge swclk) begin
    int cur;
    int a;
    cur = slot;
    slot++;
    tfall = $time;
    a = 8 + tgt_t;
    if (cur >= a && cur < a + 3)
      swdio_i = tgt_ack[cur - a];
    else if (tgt_ack == 3'b001 && tgt_rnw && cur >= a + 3 && cur < a + 35)
      swdio_i = tgt_rd[cur - a - 3];
    else if (tgt_ack == 3'b001 && tgt_rnw && cur == a + 35)
      swdio_i = (^tgt_rd) ^ tgt_bad;
    else
      swdio_i = 1'b1;
  end

  always @(posedge swclk) begin
    if (slot > 0 && slot <= 512) begin
      ro[slot-1]  = swdio_o;
      roe[slot-1] = swdio_oe;
      if (slot == 1) lowlen = int'(($time - tfall) / 8);
    end
  end

  task automatic xfer(input logic [3:0] sel, input logic [31:0] wd,
                      input logic [1:0] trn, input logic [7:0] idl,
                      input bit dph, input logic [7:0] half,
                      input logic [2:0] ackv, input logic [31:0] rd,
                      input bit bad, input bit probe);
    exp_t e;
    int t;
    t = trn + 1;
    e.rnw = sel[1]; e.dph = dph; e.t = t; e.idl = idl; e.wd = wd;
    e.half = (half == 0) ? 1 : half;
    e.hdr = {2'b10, ^sel, sel, 1'b1};
    e.kind = (ackv == 3'b001) ? 0 : (ackv == 3'b010 || ackv == 3'b100) ? 1 : 2;
    e.chk_rd = (e.kind == 0) && sel[1];
    e.rdata = rd;
    e.resp = (e.chk_rd && bad) ? 4'b1000 : {1'b0, ackv};
    e.nslots = 11 + t;
    if (e.kind == 0) e.nslots += 33 + t + idl;
    else if (e.kind == 1) e.nslots += dph ? 33 + t : t;
    else e.nslots += t + 33;
    q.push_back(e);
    ntx++;
    tgt_t = t; tgt_ack = ackv; tgt_rd = rd; tgt_bad = bad; tgt_rnw = sel[1];
    slot = 0;
    @(negedge clk);
    req_sel = sel; req_wdata = wd; cfg_turn = trn; cfg_idle = idl;
    cfg_dphase = dph; cfg_half = half; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1, "R10 busy after strobe", busy, 1);
    if (probe) begin
      repeat (20) @(negedge clk);
      chk(busy == 1, "R10 busy during access", busy, 1);
      req_sel = ~sel; req_valid = 1;
      @(negedge clk);
      req_valid = 0; req_sel = sel;
    end
    wait (ndone == ntx);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    if (done) begin
      ndone++;
      if (q.size() == 0) begin
        chk(0, "R10 unexpected done", 1, 0);
      end else begin
        exp_t e;
        logic [7:0] hv;
        bit ok;
        e = q.pop_front();
        if (e.kind == 0 && e.chk_rd && e.resp == 4'b1000)
          chk(resp == e.resp, "R4 parity error status", resp, e.resp);
        else if (e.kind == 0)
          chk(resp == e.resp, "R3 OK status", resp, e.resp);
        else if (e.kind == 1)
          chk(resp == e.resp, "R7 wait/fault status", resp, e.resp);
        else
          chk(resp == e.resp, "R8 protocol status", resp, e.resp);
        if (e.chk_rd) chk(rdata == e.rdata, "R3 read word", rdata, e.rdata);
        if (e.kind == 2) chk(slot == e.nslots, "R8 slot count", slot, e.nslots);
        else if (e.kind == 1) chk(slot == e.nslots, "R7 slot count", slot, e.nslots);
        else chk(slot == e.nslots, "R6 slot count", slot, e.nslots);
        ok = 1;
        for (int i = 0; i < 8; i++) begin hv[i] = ro[i]; ok &= (roe[i] === 1'b1); end
        chk(ok && hv == e.hdr, "R1 header", hv, e.hdr);
        ok = 1;
        for (int i = 8; i < 8 + e.t; i++) ok &= (roe[i] === 1'b0);
        chk(ok, "R2 turnaround released", ok, 1);
        if (e.kind == 0 && !e.rnw) begin
          logic [32:0] wv, we;
          we = {^e.wd, e.wd};
          ok = 1;
          for (int i = 0; i < 33; i++) begin
            wv[i] = ro[11 + 2*e.t + i]; ok &= (roe[11 + 2*e.t + i] === 1'b1);
          end
          chk(ok && wv == we, "R5 write bits", wv, we);
        end
        if (e.kind == 0 && e.idl > 0) begin
          ok = 1;
          for (int i = e.nslots - e.idl; i < e.nslots; i++)
            ok &= (roe[i] === 1'b1) && (ro[i] === 1'b0);
          chk(ok, "R6 idle slots low", ok, 1);
        end
        if (e.kind == 1 && e.dph) begin
          ok = 1;
          if (e.rnw) for (int i = 11 + e.t; i < 44 + e.t; i++) ok &= (roe[i] === 1'b0);
          else for (int i = e.nslots - 33; i < e.nslots; i++)
            ok &= (roe[i] === 1'b1) && (ro[i] === 1'b0);
          chk(ok, "R7 dummy phase", ok, 1);
        end
        if (e.kind == 2) begin
          ok = 1;
          for (int i = 11 + e.t; i < e.nslots; i++) ok &= (roe[i] === 1'b0);
          chk(ok, "R8 backoff released", ok, 1);
        end
        chk(lowlen == e.half, "R9 low half length", lowlen, e.half);
        chk(swclk && swdio_oe && swdio_o && !busy, "R6 end state high",
            {swclk, swdio_oe, swdio_o, busy}, 4'b1110);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(swclk && swdio_oe && swdio_o && !busy && !done, "R11 reset state",
        {swclk, swdio_oe, swdio_o, busy, done}, 5'b11100);
    //   sel    wdata          turn idle dph half ack    rdata          bad probe
    xfer(4'b0111, 32'h0,        2'd0, 8'd0, 0, 8'd1, 3'b001, 32'hA5C3_0F01, 0, 0);
    xfer(4'b1000, 32'h1234_5678, 2'd1, 8'd4, 0, 8'd2, 3'b001, 32'h0,         0, 0);
    xfer(4'b0010, 32'h0,        2'd0, 8'd2, 0, 8'd0, 3'b001, 32'hFFFF_0001, 1, 0);
    xfer(4'b0110, 32'h0,        2'd2, 8'd3, 1, 8'd1, 3'b010, 32'h0,         0, 0);
    xfer(4'b0101, 32'hDEAD_BEEF, 2'd0, 8'd3, 1, 8'd1, 3'b100, 32'h0,         0, 0);
    xfer(4'b1100, 32'h0F0F_0F0F, 2'd3, 8'd1, 0, 8'd1, 3'b010, 32'h0,         0, 0);
    xfer(4'b1010, 32'h0,        2'd1, 8'd1, 1, 8'd1, 3'b111, 32'h0,         0, 0);
    xfer(4'b0001, 32'h8000_0001, 2'd0, 8'd1, 1, 8'd1, 3'b000, 32'h0,         0, 0);
    xfer(4'b0000, 32'hFFFF_FFFE, 2'd0, 8'd0, 0, 8'd3, 3'b001, 32'h0,         0, 1);
    xfer(4'b1011, 32'h0,        2'd3, 8'd3, 0, 8'd2, 3'b001, 32'h7654_3210, 0, 1);
    repeat (100) @(negedge clk);
    chk(ndone == ntx && q.size() == 0, "R10 no extra completion", ndone, ntx);
    summary();
  end
endmodule